// File: doc/BRIEF.md
# Serial Configuration Port with Shared Input Pins

This block lets a configuration word be written into a chip, and read back, over four pins that are ordinary logic inputs the rest of the time. An active-low enable selects the pin role. While the enable is high, the four pins pass straight through to the core logic and the readback pin is never driven. While the enable is low, one pin is the serial data input, one is the shift clock, one is the mode control, and the fourth returns serial readback data.

A small four-state machine (idle, shift, load, verify) is steered on each rising shift-clock edge. With the mode pin high, the machine moves to another state and the data pin acts as the branch bit. With the mode pin low, it carries out the action of its current state. The configuration latch that the rest of the chip sees changes only through the load action, so the core never sees a partly shifted word. The pins are assumed to be already synchronous to the system clock. The shift clock is sampled and its rising edge is detected in the system clock domain.

Top module: `cfg_serial_port`

## Requirements
- R1: While `prog_en_n` is 1, `logic_in` equals {`pin_sdo_in`, `pin_sdi`, `pin_mode`, `pin_sclk`} (bit 3 down to bit 0) in the same cycle, and `pin_sdo_oe` is 0.
- R2: While `prog_en_n` is 0, `logic_in` is 0 and `pin_sdo_oe` is 1.
- R3: After a synchronous reset the machine is idle, `cfg_q` holds `CFG_RESET` (default 8'hA5), and `pin_sdo_out` is 0.
- R4: A rising `pin_sclk` edge with `pin_mode`=1 changes state by branch bit `pin_sdi`. From idle: 1 goes to shift, 0 stays idle. From shift: 1 goes to load, 0 goes to verify. From load or verify: 1 goes to idle, 0 goes to shift.
- R5: A rising `pin_sclk` edge with `pin_mode`=0 in the shift state shifts the register left and takes `pin_sdi` into bit 0. In programming mode, `pin_sdo_out` shows register bit CFG_W-1 while in the shift state and is 0 in every other state, so a word leaves most significant bit first.
- R6: A rising `pin_sclk` edge with `pin_mode`=0 in the load state copies the shift register into `cfg_q`. `cfg_q` changes by no other means except reset.
- R7: A rising `pin_sclk` edge with `pin_mode`=0 in the verify state copies `cfg_q` into the shift register for readback.
- R8: While `prog_en_n` is 1, the machine is forced to idle one cycle later and `pin_sclk` edges have no effect on the shift register or `cfg_q`. The shift register keeps its contents.
- R9: Each rising `pin_sclk` edge causes exactly one step. Holding `pin_sclk` high for many cycles does not repeat it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en_n | input | 1 | Active-low programming enable |
| pin_sclk | input | 1 | Shift clock pin / logic input 0 |
| pin_mode | input | 1 | Mode control pin / logic input 1 |
| pin_sdi | input | 1 | Serial data and branch bit pin / logic input 2 |
| pin_sdo_in | input | 1 | Incoming value of the readback pin / logic input 3 |
| pin_sdo_out | output | 1 | Readback data driven onto the readback pin |
| pin_sdo_oe | output | 1 | Output enable for the readback pin |
| logic_in | output | 4 | Dedicated inputs as seen by the core logic |
| cfg_q | output | CFG_W | Configuration latch contents |

## Verification
The pin multiplexing is combinational, so `logic_in` and `pin_sdo_oe` are checked in the same half-cycle in which the enable and pins are driven. A shift-clock pulse is raised at one falling clock edge. Its action lands at the next rising edge, because the edge detector and the state, shift and latch registers all update at that rising edge. The bench therefore samples `cfg_q` and `pin_sdo_out` at the following falling edge, against its own model of the state table and shift register. The return to idle after the enable rises takes one rising edge, and the bench checks it only after that edge.

// File: rtl/cfgp_pkg.sv
// Package: shared encodings for the serial configuration port.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cfgp_pkg;

    // Mode machine states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LOAD   = 2'd2,
        ST_VERIFY = 2'd3
    } cfgp_state_e;

    // Action requested from the shift and store datapath.
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_SHIFT   = 2'd1,
        ACT_LOAD    = 2'd2,
        ACT_CAPTURE = 2'd3
    } cfgp_act_e;

endpackage

// File: rtl/cfgp_pin_mux.sv
// Module: cfgp_pin_mux
// Routes the four shared pins either to the core logic inputs or to the
// programming function, and drives the readback pin.
// Assumes: pins are synchronous to the system clock; purely combinational.
module cfgp_pin_mux (
    input  logic       prog_en_n,
    input  logic       pin_sclk,
    input  logic       pin_mode,
    input  logic       pin_sdi,
    input  logic       pin_sdo_in,
    input  logic       shift_view,
    input  logic       sr_msb,
    output logic       prog_active,
    output logic       sdo_out,
    output logic       sdo_oe,
    output logic [3:0] logic_in
);
    logic [3:0] pin_vec;

    // Gather the pins in core-input bit order.
    always_comb begin
        pin_vec = {pin_sdo_in, pin_sdi, pin_mode, pin_sclk};
    end

    // Select the pin role from the enable.
    always_comb begin
        prog_active = ~prog_en_n;
        sdo_oe      = prog_active;
        logic_in    = prog_active ? 4'b0000 : pin_vec;
        sdo_out     = (prog_active && shift_view) ? sr_msb : 1'b0;
    end

endmodule

// File: rtl/cfgp_mode_fsm.sv
// Module: cfgp_mode_fsm
// Detects rising shift-clock edges and steers the idle/shift/load/verify
// machine: mode high branches on the data pin, mode low issues an action.
// Assumes: sclk is synchronous to clk and each level lasts at least one clk.
module cfgp_mode_fsm
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_active,
    input  logic        sclk,
    input  logic        mode,
    input  logic        sdi,
    output cfgp_state_e state,
    output cfgp_act_e   act
);
    logic        sclk_q;
    logic        step;
    cfgp_state_e state_nx;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // One step per rising shift-clock edge, only in programming mode.
    always_comb begin
        step = prog_active && sclk && !sclk_q;
    end

    // Branch table used when mode is high.
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = sdi ? ST_SHIFT : ST_IDLE;
            ST_SHIFT:  state_nx = sdi ? ST_LOAD  : ST_VERIFY;
            ST_LOAD:   state_nx = sdi ? ST_IDLE  : ST_SHIFT;
            ST_VERIFY: state_nx = sdi ? ST_IDLE  : ST_SHIFT;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register: forced idle outside programming mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_active) state <= ST_IDLE;
        else if (step && mode)      state <= state_nx;
    end

    // Action decode used when mode is low.
    always_comb begin
        act = ACT_NONE;
        if (step && !mode) begin
            unique case (state)
                ST_SHIFT:  act = ACT_SHIFT;
                ST_LOAD:   act = ACT_LOAD;
                ST_VERIFY: act = ACT_CAPTURE;
                default:   act = ACT_NONE;
            endcase
        end
    end

    // R8
    idle_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_active |=> (state == ST_IDLE));

    // R9
    hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_active && sclk && sclk_q) |=> $stable(state));

    // R4
    leave_idle_needs_sdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_SHIFT) |-> $past(sdi && mode));

endmodule

// File: rtl/cfgp_shift_store.sv
// Module: cfgp_shift_store
// Holds the serial shift register and the configuration latch and performs
// the shift, load and capture actions requested by the mode machine.
// Assumes: at most one action per clock, issued as a single-cycle code.
module cfgp_shift_store
    import cfgp_pkg::*;
#(
    parameter int unsigned     CFG_W     = 8,
    parameter logic [CFG_W-1:0] CFG_RESET = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfgp_act_e        act,
    input  logic             sdi,
    output logic             sr_msb,
    output logic [CFG_W-1:0] cfg
);
    localparam int unsigned MSB = CFG_W - 1;

    logic [CFG_W-1:0] sr;

    // Shift register: shift in at bit 0 or capture the latch for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sr <= '0;
        else if (act == ACT_SHIFT)    sr <= {sr[MSB-1:0], sdi};
        else if (act == ACT_CAPTURE)  sr <= cfg;
    end

    // Configuration latch: updated only by the load action.
    always_ff @(posedge clk) begin
        if (!rst_n)                cfg <= CFG_RESET;
        else if (act == ACT_LOAD)  cfg <= sr;
    end

    // Expose the bit that leaves first.
    always_comb begin
        sr_msb = sr[MSB];
    end

    // R6
    cfg_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> ($past(act) == ACT_LOAD));

    // R5
    shift_in_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SHIFT) |=> (sr[0] == $past(sdi)));

    // R7
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CAPTURE) |=> (sr == $past(cfg)));

endmodule

// File: rtl/cfg_serial_port.sv
// Module: cfg_serial_port (top)
// Serial configuration port sharing four pins with dedicated logic inputs.
// Assumes: all pins synchronous to clk; synchronous active-low reset.
module cfg_serial_port
    import cfgp_pkg::*;
#(
    parameter int unsigned      CFG_W     = 8,
    parameter logic [CFG_W-1:0] CFG_RESET = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en_n,
    input  logic             pin_sclk,
    input  logic             pin_mode,
    input  logic             pin_sdi,
    input  logic             pin_sdo_in,
    output logic             pin_sdo_out,
    output logic             pin_sdo_oe,
    output logic [3:0]       logic_in,
    output logic [CFG_W-1:0] cfg_q
);
    logic        prog_active;
    logic        shift_view;
    logic        sr_msb;
    cfgp_state_e state;
    cfgp_act_e   act;

    cfgp_pin_mux i_mux (
        .prog_en_n  (prog_en_n),
        .pin_sclk   (pin_sclk),
        .pin_mode   (pin_mode),
        .pin_sdi    (pin_sdi),
        .pin_sdo_in (pin_sdo_in),
        .shift_view (shift_view),
        .sr_msb     (sr_msb),
        .prog_active(prog_active),
        .sdo_out    (pin_sdo_out),
        .sdo_oe     (pin_sdo_oe),
        .logic_in   (logic_in)
    );

    cfgp_mode_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_active(prog_active),
        .sclk       (pin_sclk),
        .mode       (pin_mode),
        .sdi        (pin_sdi),
        .state      (state),
        .act        (act)
    );

    cfgp_shift_store #(
        .CFG_W    (CFG_W),
        .CFG_RESET(CFG_RESET)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .sdi   (pin_sdi),
        .sr_msb(sr_msb),
        .cfg   (cfg_q)
    );

    // Readback shows the register only in the shift state.
    always_comb begin
        shift_view = (state == ST_SHIFT);
    end

    // R1
    oe_off_outside_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en_n |-> !pin_sdo_oe);

    // R8
    cfg_frozen_outside_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_n && $past(prog_en_n)) |-> $stable(cfg_q));

endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
    localparam int W = 8;
    localparam logic [W-1:0] RST_VAL = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en_n = 1'b1;
    logic pin_sclk = 1'b0, pin_mode = 1'b0, pin_sdi = 1'b0, pin_sdo_in = 1'b0;
    logic pin_sdo_out, pin_sdo_oe;
    logic [3:0] logic_in;
    logic [W-1:0] cfg_q;

    int checks = 0;
    int errors = 0;

    // bench model
    int           m_st = 0;       // 0 idle, 1 shift, 2 load, 3 verify
    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_cfg = RST_VAL;

    always #5 clk = ~clk;

    cfg_serial_port #(.CFG_W(W), .CFG_RESET(RST_VAL)) i_cfg_serial_port (
        .clk(clk), .rst_n(rst_n), .prog_en_n(prog_en_n),
        .pin_sclk(pin_sclk), .pin_mode(pin_mode), .pin_sdi(pin_sdi),
        .pin_sdo_in(pin_sdo_in), .pin_sdo_out(pin_sdo_out), .pin_sdo_oe(pin_sdo_oe),
        .logic_in(logic_in), .cfg_q(cfg_q)
    );

    task automatic chk(input string req, input logic [W-1:0] act_v, input logic [W-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
        end
    endtask

    function automatic logic exp_sdo();
        return (!prog_en_n && m_st == 1) ? m_sr[W-1] : 1'b0;
    endfunction

    task automatic model_step(input logic m, input logic d);
        if (prog_en_n) return;
        if (m) begin
            case (m_st)
                0: m_st = d ? 1 : 0;
                1: m_st = d ? 2 : 3;
                default: m_st = d ? 0 : 1;
            endcase
        end else begin
            case (m_st)
                1: m_sr = {m_sr[W-2:0], d};
                2: m_cfg = m_sr;
                3: m_sr = m_cfg;
                default: ;
            endcase
        end
    endtask

    // One shift-clock pulse; action lands at the rising edge, sampled at next negedge.
    task automatic pulse(input logic m, input logic d, input string req);
        @(negedge clk);
        pin_mode = m; pin_sdi = d; pin_sclk = 1'b1;
        @(negedge clk);
        pin_sclk = 1'b0;
        model_step(m, d);
        chk({req, " cfg"}, cfg_q, m_cfg);
        chk({req, " sdo"}, {7'b0, pin_sdo_out}, {7'b0, exp_sdo()});
    endtask

    task automatic write_word(input logic [W-1:0] v);
        pulse(1'b1, 1'b1, "R4 idle->shift");
        for (int i = W - 1; i >= 0; i--) pulse(1'b0, v[i], "R5 shift");
        pulse(1'b1, 1'b1, "R4 shift->load");
        pulse(1'b0, 1'b0, "R6 load");
        chk("R6 written word", cfg_q, v);
        pulse(1'b1, 1'b1, "R4 load->idle");
    endtask

    task automatic read_word(input logic [W-1:0] v);
        pulse(1'b1, 1'b1, "R4 idle->shift");
        pulse(1'b1, 1'b0, "R4 shift->verify");
        pulse(1'b0, 1'b0, "R7 capture");
        pulse(1'b1, 1'b0, "R4 verify->shift");
        for (int i = W - 1; i >= 0; i--) begin
            chk("R7 readback bit", {7'b0, pin_sdo_out}, {7'b0, v[i]});
            pulse(1'b0, 1'b0, "R5 shift out");
        end
        pulse(1'b1, 1'b1, "R4 shift->load");
        pulse(1'b1, 1'b1, "R4 load->idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 reset state
        chk("R3 cfg reset", cfg_q, RST_VAL);
        chk("R3 sdo reset", {7'b0, pin_sdo_out}, 8'h00);

        // R1 pass-through sweep
        for (int p = 0; p < 16; p++) begin
            pin_sclk = p[0]; pin_mode = p[1]; pin_sdi = p[2]; pin_sdo_in = p[3];
            #1;
            chk("R1 logic_in", {4'b0, logic_in}, p[7:0]);
            chk("R1 oe", {7'b0, pin_sdo_oe}, 8'h00);
            @(negedge clk);
        end
        chk("R8 cfg untouched by pass-through", cfg_q, RST_VAL);
        pin_sclk = 1'b0; pin_mode = 1'b0; pin_sdi = 1'b0; pin_sdo_in = 1'b0;
        @(negedge clk);

        // R2 programming-mode pin sweep (mode held low, no sclk edges)
        prog_en_n = 1'b0;
        for (int p = 0; p < 16; p++) begin
            pin_mode = 1'b0; pin_sdi = p[2]; pin_sdo_in = p[3];
            #1;
            chk("R2 logic_in", {4'b0, logic_in}, 8'h00);
            chk("R2 oe", {7'b0, pin_sdo_oe}, 8'h01);
            @(negedge clk);
        end
        pin_sdi = 1'b0; pin_sdo_in = 1'b0;

        // R4 idle stays idle on branch 0; mode-low in idle does nothing
        pulse(1'b1, 1'b0, "R4 idle stay");
        pulse(1'b0, 1'b1, "R4 idle no action");

        // R5/R6/R7 exhaustive write and readback sweep
        for (int v = 0; v < 256; v++) begin
            write_word(v[W-1:0]);
            read_word(v[W-1:0]);
        end

        // R4 other branches: load->shift and verify->idle
        pulse(1'b1, 1'b1, "R4 idle->shift");
        pulse(1'b1, 1'b1, "R4 shift->load");
        pulse(1'b1, 1'b0, "R4 load->shift");
        pulse(1'b1, 1'b0, "R4 shift->verify");
        pulse(1'b1, 1'b1, "R4 verify->idle");
        pulse(1'b0, 1'b1, "R4 idle no action");

        // R9 long sclk high gives exactly one shift
        pulse(1'b1, 1'b1, "R9 idle->shift");
        @(negedge clk);
        pin_mode = 1'b0; pin_sdi = 1'b1; pin_sclk = 1'b1;
        repeat (6) @(negedge clk);
        model_step(1'b0, 1'b1);
        chk("R9 single shift sdo", {7'b0, pin_sdo_out}, {7'b0, exp_sdo()});
        pin_sclk = 1'b0;
        @(negedge clk);
        for (int i = 0; i < W; i++) pulse(1'b0, 1'b0, "R9 drain");
        pulse(1'b1, 1'b1, "R9 shift->load");
        pulse(1'b0, 1'b0, "R9 load");

        // R8 leave programming mode mid-shift; edges ignored
        pulse(1'b1, 1'b0, "R8 load->shift");
        pulse(1'b0, 1'b1, "R8 shift one");
        @(negedge clk);
        prog_en_n = 1'b1;
        m_st = 0;
        @(negedge clk);
        pulse(1'b0, 1'b1, "R8 ignored edge");
        pulse(1'b1, 1'b1, "R8 ignored branch");
        pulse(1'b0, 1'b0, "R8 ignored edge 2");
        prog_en_n = 1'b0;
        @(negedge clk);
        pulse(1'b0, 1'b1, "R8 back idle no action");
        pulse(1'b1, 1'b1, "R8 idle->shift kept register");
        chk("R8 sdo shows kept register", {7'b0, pin_sdo_out}, {7'b0, m_sr[W-1]});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule